// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the timing of a reference input with a feedback input, usually the divided oscillator output of a PLL. It uses only their rising edges. Both inputs are asynchronous to the system clock. They pass through a synchronizer, and an edge is detected when the current sample is 1 and the previous sample was 0. Because only those transitions count, the duty cycle of either input has no effect on the result.

The result is a three-valued charge command. It is modelled as an enable (`driveEn`) plus a level (`driveLevel`). When the reference edge comes first, the block drives high until the matching feedback edge arrives. When the feedback edge comes first, it drives low until the reference edge arrives. In every other case the output is released, which is the high-impedance state. While the output is released, `phasePulse` is high, so it can serve as a lock indicator.

If the feedback runs slow, surplus reference edges keep the output driven high. If the feedback runs fast, or no reference is present, the output stays driven low. A spurious reference pulse counts as a real edge. It holds the output high until the next feedback edge arrives.

Top module: `tri_state_pfd`

## Requirements
- R1: Only rising edges of `refIn` and `fbIn` act on the outputs. A held high level and a falling edge leave all outputs unchanged.
- R2: From the released state, a lone reference edge sets `driveEn`=1 and `driveLevel`=1. This state holds until a feedback edge is seen, and that edge releases the output.
- R3: From the released state, a lone feedback edge sets `driveEn`=1 and `driveLevel`=0. This state holds until a reference edge is seen, and that edge releases the output.
- R4: `phasePulse` is 1 exactly when `driveEn` is 0. While the output is released, `driveLevel` reads 0.
- R5: Further reference edges while driving high keep the output high. Further feedback edges while driving low keep it low, which includes the case where no reference edges arrive at all.
- R6: If a reference edge and a feedback edge are detected in the same clock cycle, the output is released, whatever the prior state. No up or down drive results.
- R7: Synchronous active-high `rst` forces `driveEn`=0, `driveLevel`=0 and `phasePulse`=1 on the next clock edge.
- R8: With `SYNC_STAGES`=2, an input rise that is set up before a clock edge appears at the outputs on the third rising clock edge from that point, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both inputs |
| rst | input | 1 | Synchronous active-high reset |
| refIn | input | 1 | Reference input, asynchronous |
| fbIn | input | 1 | Feedback (oscillator) input, asynchronous |
| driveEn | output | 1 | 1 = output driven, 0 = released (high-impedance) |
| driveLevel | output | 1 | Drive level while `driveEn` is 1 (1 = up, 0 = down) |
| phasePulse | output | 1 | High while the output is released |

## Verification
The two functions that can fall in the same cycle are the detection of a reference edge and the detection of a feedback edge. When both occur together, the release rule has to win over both the up decision and the down decision. The bench provokes this by raising both inputs on the same clock phase, starting from each of the released, driving-high and driving-low states. It judges the outcome three clocks later by requiring a released output with `phasePulse` high.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic refRise;
    logic fbRise;
  } edgePair_t;

  typedef struct packed {
    logic setUp;
    logic setDown;
    logic goIdle;
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refIn,
  input  logic       fbIn,
  input  pfdStrobe_t strb,
  output edgePair_t  edges,
  output logic       driveEn,
  output logic       driveLevel,
  output logic       phasePulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] refSync, fbSync;
  logic refPrev, fbPrev;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) begin
            refSync[0] <= 1'b0;
            fbSync[0]  <= 1'b0;
          end else begin
            refSync[0] <= refIn;
            fbSync[0]  <= fbIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) begin
            refSync[g] <= 1'b0;
            fbSync[g]  <= 1'b0;
          end else begin
            refSync[g] <= refSync[g-1];
            fbSync[g]  <= fbSync[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refSync[LAST];
      fbPrev  <= fbSync[LAST];
    end
  end

  assign edges.refRise = refSync[LAST] & ~refPrev;
  assign edges.fbRise  = fbSync[LAST] & ~fbPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      driveEn    <= 1'b0;
      driveLevel <= 1'b0;
      phasePulse <= 1'b1;
    end else if (strb.goIdle) begin
      driveEn    <= 1'b0;
      driveLevel <= 1'b0;
      phasePulse <= 1'b1;
    end else if (strb.setUp) begin
      driveEn    <= 1'b1;
      driveLevel <= 1'b1;
      phasePulse <= 1'b0;
    end else if (strb.setDown) begin
      driveEn    <= 1'b1;
      driveLevel <= 1'b0;
      phasePulse <= 1'b0;
    end
  end

  // R4: lock pulse and enable are separate registers; they must stay complementary
  a_r4_pulse_when_released: assert property (@(posedge clk) disable iff (rst)
    (phasePulse == !driveEn) && (driveEn || !driveLevel));
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  edgePair_t  edges,
  input  logic       driveEn,
  input  logic       driveLevel,
  output pfdStrobe_t strb
);
  logic isUp, isDown;

  assign isUp   = driveEn & driveLevel;
  assign isDown = driveEn & ~driveLevel;

  always_comb begin
    strb.goIdle  = (edges.refRise & edges.fbRise)
                 | (isUp & edges.fbRise)
                 | (isDown & edges.refRise);
    strb.setUp   = edges.refRise & ~edges.fbRise & ~isDown;
    strb.setDown = edges.fbRise & ~edges.refRise & ~isUp;
  end

  // R6: never ask for a drive while a release is requested
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    strb.goIdle |-> !(strb.setUp || strb.setDown));
endmodule

// File: rtl/tri_state_pfd.sv
module tri_state_pfd
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refIn,
  input  logic fbIn,
  output logic driveEn,
  output logic driveLevel,
  output logic phasePulse
);
  edgePair_t  edges;
  pfdStrobe_t strb;

  pfd_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn), .strb(strb),
    .edges(edges), .driveEn(driveEn), .driveLevel(driveLevel),
    .phasePulse(phasePulse)
  );

  pfd_control ctl_i (
    .clk(clk), .rst(rst), .edges(edges), .driveEn(driveEn),
    .driveLevel(driveLevel), .strb(strb)
  );

  a_r6_both_edges_release: assert property (@(posedge clk) disable iff (rst)
    (edges.refRise && edges.fbRise) |=> (!driveEn && phasePulse));

  a_r2_up_holds: assert property (@(posedge clk) disable iff (rst)
    (driveEn && driveLevel && !edges.fbRise) |=> (driveEn && driveLevel));

  a_r3_down_holds: assert property (@(posedge clk) disable iff (rst)
    (driveEn && !driveLevel && !edges.refRise) |=> (driveEn && !driveLevel));

  a_r1_no_edge_no_change: assert property (@(posedge clk) disable iff (rst)
    (!edges.refRise && !edges.fbRise) |=> ($stable(driveEn) && $stable(driveLevel)));
endmodule

// File: tb/tri_state_pfd_tb_top.sv
module tri_state_pfd_tb_top;
  logic clk = 1'b0;
  logic rst, refIn, fbIn;
  logic driveEn, driveLevel, phasePulse;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tri_state_pfd #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .driveEn(driveEn), .driveLevel(driveLevel), .phasePulse(phasePulse)
  );

  // {refPulse, fbPulse, expEn, expLevel, expPulse}
  localparam logic [4:0] VEC [13] = '{
    5'b10_110, // R2 reference first -> up
    5'b10_110, // R5 extra reference keeps up
    5'b01_001, // R2 feedback releases
    5'b01_100, // R3 feedback first -> down
    5'b01_100, // R5 extra feedback keeps down
    5'b10_001, // R3 reference releases
    5'b11_001, // R6 both from released
    5'b10_110, // R2 up again
    5'b11_001, // R6 both while up
    5'b01_100, // R3 down again
    5'b11_001, // R6 both while down
    5'b10_110, // R2
    5'b01_001  // R2
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b (en,level,pulse)", req, act, exp);
    end
  endtask

  task automatic edgeStep(input logic r, input logic f);
    @(negedge clk);
    refIn = r;
    fbIn = f;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dropInputs();
    @(negedge clk);
    refIn = 1'b0;
    fbIn = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rst = 1'b1; refIn = 1'b0; fbIn = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 reset state", {driveEn, driveLevel, phasePulse}, 3'b001);
    rst = 1'b0;

    foreach (VEC[i]) begin
      edgeStep(VEC[i][4], VEC[i][3]);
      check($sformatf("R2/R3/R5/R6 vector %0d", i), {driveEn, driveLevel, phasePulse}, VEC[i][2:0]);
      dropInputs();
      check($sformatf("R1 falling edge vector %0d", i), {driveEn, driveLevel, phasePulse}, VEC[i][2:0]);
    end

    // R1: wide reference level, only one rise counts
    edgeStep(1'b1, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R1 held high level", {driveEn, driveLevel, phasePulse}, 3'b110);
    edgeStep(1'b1, 1'b1);
    check("R1 feedback rise releases despite held ref", {driveEn, driveLevel, phasePulse}, 3'b001);
    dropInputs();

    // R5: no reference at all, only feedback edges
    for (int k = 0; k < 4; k++) begin
      edgeStep(1'b0, 1'b1);
      dropInputs();
    end
    check("R5 no reference stays low", {driveEn, driveLevel, phasePulse}, 3'b100);
    edgeStep(1'b1, 1'b0);
    check("R3 reference ends down", {driveEn, driveLevel, phasePulse}, 3'b001);
    dropInputs();

    // R8: latency, two clocks not enough, three are
    @(negedge clk);
    refIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 not yet after two clocks", {driveEn, driveLevel, phasePulse}, 3'b001);
    @(posedge clk);
    @(negedge clk);
    check("R8 visible after three clocks", {driveEn, driveLevel, phasePulse}, 3'b110);
    dropInputs();

    // R7: reset while driving up
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 reset releases", {driveEn, driveLevel, phasePulse}, 3'b001);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 stays released after reset", {driveEn, driveLevel, phasePulse}, 3'b001);

    finish();
  end
endmodule